// File: doc/BRIEF.md
# Lead-Angle Commutation Timer

This block sits between three back-EMF polarity comparators and a three-phase bridge. It takes the 3-bit position code the comparators produce. Each change to a new valid code marks the start of a 60-electrical-degree sector. The block counts the clock cycles between such changes and uses that count to time the next commutation. By default the commutation falls 30 degrees after the change. When an advance is selected, it falls earlier. From a six-step commutation state it drives three high-side and three low-side switch enables. The active low-side switch is chopped by the PWM enable.

During start-up, a controller outside the block puts it in forced mode. In forced mode a strobe advances the step directly and the lead angle is zero. Once forced mode is released, position changes schedule commutations with the selected lead angle. In overlap mode, the outgoing switch is held on for a short window after each natural commutation. The window is longer when the lead angle is larger.

Top module: `lead_comm_timer`

## Requirements
- R1: During and straight after reset, the step index is 0, no commutation is pending and no overlap window is open.
- R2: Phase bit 0 is U, bit 1 is V and bit 2 is W. The six steps drive these high/low phase pairs: 0 U/V, 1 U/W, 2 V/W, 3 V/U, 4 W/U, 5 W/V. The high-side enable of the step's high phase and the low-side enable of its low phase are on.
- R3: Each commutation moves the step to (s+1) mod 6 when the direction input is 0 and to (s+5) mod 6 when it is 1. The direction is sampled when the commutation happens.
- R4: A position edge is a clock cycle in which the code is valid (neither 000 nor 111) and differs from the last valid code. The codes 000 and 111, and a return to the last valid code, schedule nothing and leave the step unchanged.
- R5: The interval is the number of clock cycles between two position edges. It saturates at 2^CNT_W-1. The counter starts saturated after reset.
- R6: Outside forced mode, a position edge seen at clock edge E schedules a commutation so that the new step shows after clock edge E+D. With interval P, D is max(1, floor(P/2)) for lead select 00 (0 degrees), max(1, floor(3P/8)) for 01 (7.5 degrees) and max(1, floor(P/4)) for 10 or 11 (15 degrees).
- R7: A position edge that arrives while a commutation is pending replaces the pending one. Each edge yields at most one step advance.
- R8: If the overlap-off input is 0 when a natural commutation fires, the outgoing step's switches stay on, together with the incoming step's, for L cycles. L is floor(P/8) for 7.5 degrees, floor(P/4) for 15 degrees and 0 for 0 degrees. If the overlap-off input is 1, there is no overlap.
- R9: While in forced mode, any pending commutation is cancelled. Position edges schedule nothing and the lead angle is zero, so there is no overlap. A step strobe advances the step (per R3) in the next cycle. A strobe outside forced mode has no effect.
- R10: When the PWM enable is 0, all low-side enables are 0. The high-side enables are not affected.
- R11: No phase ever has its high-side and low-side enables on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_i | input | 3 | Comparator polarity code, bit 0 U, bit 1 V, bit 2 W |
| dir_rev_i | input | 1 | 0 forward, 1 reverse step order |
| lead_sel_i | input | 2 | 00 0 deg, 01 7.5 deg, 1x 15 deg |
| overlap_off_i | input | 1 | 1 plain 120-degree conduction, 0 overlap commutation |
| forced_i | input | 1 | Forced (start-up) commutation mode |
| force_step_i | input | 1 | Step strobe used in forced mode |
| pwm_i | input | 1 | PWM chopping enable for the low side |
| step_o | output | 3 | Current step index 0..5 |
| hs_o | output | 3 | High-side switch enables |
| ls_o | output | 3 | Low-side switch enables |

## Verification
The bench sweeps every lead setting, both overlap modes and both directions over varied interval lengths. At each commutation it checks the step one cycle before the scheduled point and again at that point. This exposes off-by-one delay counting and wrong fraction arithmetic, either of which would shift the commutation by a cycle or more. It also drives a saturated interval, where a counter that wraps would produce a tiny delay. It sends a second edge before the first commutation fires; a design that keeps the stale schedule would advance twice. Entering forced mode with a commutation pending, strobing outside forced mode, and holding invalid or repeated codes would each show up as a spurious step advance or a leftover overlap window.

// File: rtl/comm_pkg.sv
package comm_pkg;

  localparam int NUM_STEPS = 6;

  typedef logic [2:0] step_t;
  typedef logic [2:0] phase_t;

  typedef enum logic [1:0] {
    LEAD_0   = 2'd0,
    LEAD_7P5 = 2'd1,
    LEAD_15  = 2'd2
  } lead_e;

  function automatic lead_e lead_decode(input logic [1:0] sel);
    lead_e r;
    case (sel)
      2'b00:   r = LEAD_0;
      2'b01:   r = LEAD_7P5;
      default: r = LEAD_15;
    endcase
    return r;
  endfunction

  function automatic step_t step_next(input step_t s, input logic rev);
    step_t r;
    if (rev) r = (s == 3'd0) ? 3'(NUM_STEPS - 1) : s - 3'd1;
    else     r = (s == 3'(NUM_STEPS - 1)) ? 3'd0 : s + 3'd1;
    return r;
  endfunction

  function automatic phase_t high_phase(input step_t s);
    phase_t r;
    case (s)
      3'd0, 3'd1: r = 3'b001;
      3'd2, 3'd3: r = 3'b010;
      default:    r = 3'b100;
    endcase
    return r;
  endfunction

  function automatic phase_t low_phase(input step_t s);
    phase_t r;
    case (s)
      3'd0, 3'd5: r = 3'b010;
      3'd1, 3'd2: r = 3'b100;
      default:    r = 3'b001;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/edge_meter.sv
module edge_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       pos_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] interval_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [2:0]       last_q, last_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             code_ok;

  always_comb begin
    code_ok = (pos_i != 3'b000) && (pos_i != 3'b111);
    edge_o  = code_ok && (pos_i != last_q);
    last_d  = edge_o ? pos_i : last_q;
    if (edge_o)                cnt_d = CNT_ONE;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + CNT_ONE;
    interval_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 3'b000;
      cnt_q  <= CNT_MAX;
    end else begin
      last_q <= last_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/comm_sched.sv
module comm_sched
  import comm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [1:0]       lead_sel_i,
  input  logic             overlap_off_i,
  input  logic             forced_i,
  output logic             fire_o,
  output logic             ovl_o
);

  localparam int PW = CNT_W + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] olen_q, olen_d;
  logic [CNT_W-1:0] ovl_q, ovl_d;

  lead_e            lead_eff;
  logic [PW-1:0]    p_ext, p_38;
  logic [CNT_W-1:0] d_raw, d_calc, l_calc;

  // delay and overlap length from the newest interval
  always_comb begin
    lead_eff = forced_i ? LEAD_0 : lead_decode(lead_sel_i);
    p_ext    = PW'(interval_i);
    p_38     = (p_ext * PW'(3)) >> 3;
    case (lead_eff)
      LEAD_7P5: begin
        d_raw  = CNT_W'(p_38);
        l_calc = interval_i >> 3;
      end
      LEAD_15: begin
        d_raw  = interval_i >> 2;
        l_calc = interval_i >> 2;
      end
      default: begin
        d_raw  = interval_i >> 1;
        l_calc = '0;
      end
    endcase
    d_calc = (d_raw == '0) ? ONE : d_raw;
  end

  // next state
  always_comb begin
    fire_o  = armed_q && !forced_i && (dly_q <= ONE);
    armed_d = armed_q;
    dly_d   = dly_q;
    olen_d  = olen_q;
    ovl_d   = (ovl_q != '0) ? ovl_q - ONE : ovl_q;

    if (fire_o) ovl_d = overlap_off_i ? '0 : olen_q;

    if (forced_i) begin
      armed_d = 1'b0;
      ovl_d   = '0;
    end else if (edge_i) begin
      armed_d = 1'b1;
      dly_d   = d_calc;
      olen_d  = l_calc;
    end else if (fire_o) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      dly_d   = dly_q - ONE;
    end
    ovl_o = (ovl_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dly_q   <= '0;
      olen_q  <= '0;
      ovl_q   <= '0;
    end else begin
      armed_q <= armed_d;
      dly_q   <= dly_d;
      olen_q  <= olen_d;
      ovl_q   <= ovl_d;
    end
  end

endmodule

// File: rtl/step_seq.sv
module step_seq
  import comm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_i,
  input  logic       strobe_i,
  input  logic       dir_rev_i,
  input  logic       ovl_i,
  input  logic       pwm_i,
  output logic [2:0] step_o,
  output logic [2:0] hs_o,
  output logic [2:0] ls_o
);

  step_t step_q, step_d, prev_q;
  logic  adv_en;

  always_comb begin
    adv_en = fire_i | strobe_i;
    step_d = step_next(step_q, dir_rev_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 3'd0;
      prev_q <= 3'd0;
    end else if (adv_en) begin
      step_q <= step_d;
      prev_q <= step_q;
    end
  end

  always_comb begin
    phase_t hi_sel, lo_sel;
    hi_sel = high_phase(step_q);
    lo_sel = low_phase(step_q);
    if (ovl_i) begin
      hi_sel = hi_sel | high_phase(prev_q);
      lo_sel = lo_sel | low_phase(prev_q);
    end
    step_o = step_q;
    hs_o   = hi_sel;
    ls_o   = pwm_i ? lo_sel : 3'b000;
  end

endmodule

// File: rtl/lead_comm_timer.sv
module lead_comm_timer
  import comm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pos_i,
  input  logic       dir_rev_i,
  input  logic [1:0] lead_sel_i,
  input  logic       overlap_off_i,
  input  logic       forced_i,
  input  logic       force_step_i,
  input  logic       pwm_i,
  output logic [2:0] step_o,
  output logic [2:0] hs_o,
  output logic [2:0] ls_o
);

  logic             pos_edge;
  logic [CNT_W-1:0] interval;
  logic             fire;
  logic             ovl_open;
  logic             strobe;

  assign strobe = forced_i & force_step_i;

  edge_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos_i      (pos_i),
    .edge_o     (pos_edge),
    .interval_o (interval)
  );

  comm_sched #(.CNT_W(CNT_W)) u_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .edge_i        (pos_edge),
    .interval_i    (interval),
    .lead_sel_i    (lead_sel_i),
    .overlap_off_i (overlap_off_i),
    .forced_i      (forced_i),
    .fire_o        (fire),
    .ovl_o         (ovl_open)
  );

  step_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .strobe_i  (strobe),
    .dir_rev_i (dir_rev_i),
    .ovl_i     (ovl_open),
    .pwm_i     (pwm_i),
    .step_o    (step_o),
    .hs_o      (hs_o),
    .ls_o      (ls_o)
  );

endmodule

// File: rtl/comm_checker.sv
module comm_checker
  import comm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       forced_i,
  input logic       force_step_i,
  input logic       pwm_i,
  input logic [2:0] step_o,
  input logic [2:0] hs_o,
  input logic [2:0] ls_o
);

  a_r11_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o & ls_o) == 3'b000);

  a_r2_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_o < 3'(NUM_STEPS));

  a_r3_adjacent_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != $past(step_o)) |->
      (step_o == step_next($past(step_o), 1'b0)) ||
      (step_o == step_next($past(step_o), 1'b1)));

  a_r9_forced_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_i && !force_step_i) |=> $stable(step_o));

  a_r9_forced_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_i && $past(forced_i)) |-> ($countones(hs_o) == 1));

  a_r10_pwm_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_i |-> (ls_o == 3'b000));

endmodule

bind lead_comm_timer comm_checker u_comm_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .forced_i     (forced_i),
  .force_step_i (force_step_i),
  .pwm_i        (pwm_i),
  .step_o       (step_o),
  .hs_o         (hs_o),
  .ls_o         (ls_o)
);

// File: tb/lead_comm_timer_bench.sv
module lead_comm_timer_bench;

  localparam int CW   = 8;
  localparam int PMAX = (1 << CW) - 1;

  logic       clk;
  logic       rst_n;
  logic [2:0] pos_i;
  logic       dir_rev_i;
  logic [1:0] lead_sel_i;
  logic       overlap_off_i;
  logic       forced_i;
  logic       force_step_i;
  logic       pwm_i;
  logic [2:0] step_o, hs_o, ls_o;

  int checks = 0;
  int errors = 0;
  int exp_step = 0;
  int prev_gap = 0;
  int ci = 0;
  bit done = 0;
  int codes[6] = '{1, 3, 2, 6, 4, 5};

  lead_comm_timer #(.CNT_W(CW)) u_lead_comm_timer (
    .clk(clk), .rst_n(rst_n), .pos_i(pos_i), .dir_rev_i(dir_rev_i),
    .lead_sel_i(lead_sel_i), .overlap_off_i(overlap_off_i),
    .forced_i(forced_i), .force_step_i(force_step_i), .pwm_i(pwm_i),
    .step_o(step_o), .hs_o(hs_o), .ls_o(ls_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int nxt(int s, logic r);
    return r ? (s + 5) % 6 : (s + 1) % 6;
  endfunction

  function automatic logic [2:0] hi_of(int s);
    case (s)
      0, 1: return 3'b001;
      2, 3: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic [2:0] lo_of(int s);
    case (s)
      0, 5: return 3'b010;
      1, 2: return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic expect_out(string tag, int s, int p, bit ov);
    logic [2:0] eh, el;
    eh = hi_of(s) | (ov ? hi_of(p) : 3'b000);
    el = lo_of(s) | (ov ? lo_of(p) : 3'b000);
    if (!pwm_i) el = 3'b000;
    chk(tag, "step", int'(step_o), s);
    chk(tag, "hs", int'(hs_o), int'(eh));
    chk(tag, "ls", int'(ls_o), int'(el));
  endtask

  task automatic hold_check(string tag, int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    prev_gap += n;
    expect_out(tag, exp_step, 0, 0);
  endtask

  // apply the next position code and check the scheduled commutation
  task automatic edge_run(string tag, int gap_req);
    int p, d, l, g, old, nw;
    p = (prev_gap > PMAX) ? PMAX : prev_gap;
    case (lead_sel_i)
      2'b00: begin d = p / 2;       l = 0;     end
      2'b01: begin d = (3 * p) / 8; l = p / 8; end
      default: begin d = p / 4;     l = p / 4; end
    endcase
    if (d < 1) d = 1;
    if (overlap_off_i) l = 0;
    g = gap_req;
    if (g < d + l + 2) g = d + l + 2;
    old = exp_step;
    nw  = nxt(old, dir_rev_i);
    pos_i = 3'(codes[ci % 6]);
    ci++;
    for (int j = 1; j <= g; j++) begin
      @(negedge clk);
      if (j == d)     expect_out(tag, old, old, 0);
      if (j == d + 1) expect_out(tag, nw, old, l > 0);
      if (l > 0 && j == d + l + 1) expect_out("R8", nw, old, 0);
      if (j == g)     expect_out("R3", nw, old, 0);
    end
    exp_step = nw;
    prev_gap = g;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int gaps[4] = '{24, 30, 36, 28};
    rst_n = 0; pos_i = 3'b000; dir_rev_i = 0; lead_sel_i = 2'b00;
    overlap_off_i = 1; forced_i = 0; force_step_i = 0; pwm_i = 1;
    repeat (3) @(negedge clk);
    expect_out("R1", 0, 0, 0);
    pwm_i = 0; #1;
    expect_out("R10", 0, 0, 0);
    pwm_i = 1;
    @(negedge clk);
    rst_n = 1;
    prev_gap = 1000;

    // R4: invalid codes right after reset
    pos_i = 3'b111; hold_check("R4", 20);
    pos_i = 3'b000; hold_check("R4", 20);

    // R5: first interval comes from the saturated counter
    edge_run("R5", 140);

    // R6 / R8 / R3 sweep
    for (int dr = 0; dr < 2; dr++) begin
      for (int om = 0; om < 2; om++) begin
        for (int ld = 0; ld < 3; ld++) begin
          dir_rev_i = dr[0];
          overlap_off_i = om[0];
          lead_sel_i = 2'(ld);
          for (int k = 0; k < 4; k++) edge_run((om == 0 && ld > 0) ? "R8" : "R6", gaps[k]);
        end
      end
    end
    dir_rev_i = 0; overlap_off_i = 0; lead_sel_i = 2'b10;

    // R4: invalid codes and a return to the last valid code
    pos_i = 3'b000; hold_check("R4", 30);
    pos_i = 3'b111; hold_check("R4", 30);
    pos_i = 3'(codes[(ci + 5) % 6]); hold_check("R4", 10);
    edge_run("R4", 40);

    // R7: a second edge replaces the pending commutation
    lead_sel_i = 2'b00;
    edge_run("R6", 40);
    pos_i = 3'(codes[ci % 6]); ci++;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_out("R7", exp_step, 0, 0);
    end
    prev_gap = 3;
    edge_run("R7", 50);

    // R10: PWM low during natural commutation
    pwm_i = 0;
    edge_run("R10", 40);
    edge_run("R10", 40);
    pwm_i = 1;

    // R9: forced mode cancels the pending commutation
    lead_sel_i = 2'b10; overlap_off_i = 0;
    pos_i = 3'(codes[ci % 6]); ci++;
    @(negedge clk); @(negedge clk);
    forced_i = 1;
    prev_gap = 2;
    hold_check("R9", 30);
    for (int k = 0; k < 6; k++) begin
      force_step_i = 1;
      @(negedge clk);
      force_step_i = 0;
      exp_step = nxt(exp_step, 0);
      expect_out("R2", exp_step, 0, 0);
    end
    dir_rev_i = 1;
    for (int k = 0; k < 3; k++) begin
      force_step_i = 1;
      @(negedge clk);
      force_step_i = 0;
      exp_step = nxt(exp_step, 1);
      expect_out("R3", exp_step, 0, 0);
    end
    dir_rev_i = 0;
    pos_i = 3'(codes[ci % 6]); ci++;
    prev_gap = 0;
    hold_check("R9", 40);
    forced_i = 0;
    force_step_i = 1;
    hold_check("R9", 1);
    force_step_i = 0;
    hold_check("R9", 4);
    edge_run("R9", 40);
    edge_run("R9", 40);

    // R5: saturated interval in natural mode
    lead_sel_i = 2'b00;
    hold_check("R5", 300);
    edge_run("R5", 140);
    edge_run("R6", 80);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule